// File: doc/BRIEF.md
# CPU to DRAM Command Bridge

This block sits between an 8-bit microprocessor bus with 16 address lines and the command port of a DRAM controller. Each CPU read or write becomes one handshake on the controller side. The block raises a write flag together with a strobe and a cycle-qualifier. It holds the address and data steady until the controller acknowledges, and then releases the port. The CPU is stalled through a ready output for the whole time the request is in flight.

The CPU can only see a 64 KB window. A 7-bit block-select register, loaded through its own strobe, supplies the upper address bits, so the window can be moved anywhere in 8 MB of memory. The 23-bit byte address splits into three parts: a 2-bit bank, a 20-bit index of a 16-bit word, and a byte-select bit. The controller data path is 32 bits wide. The addressed word uses the low 16 bits of it, and the block inserts or extracts the byte that was asked for.

Top module: `cpu_dram_bridge`

## Requirements
- R1: After reset, mem_stb, mem_cyc and mem_we are 0, cpu_ready is 1, cpu_rdata is 0, and the block-select register holds 0. The CPU therefore starts in the lowest 64 KB.
- R2: When cpu_ready is 1 and cpu_rd_req is 1 (with cpu_wr_req 0) at a clock edge, the next cycle shows mem_stb=1, mem_cyc=1, mem_we=0 and cpu_ready=0.
- R3: When cpu_ready is 1 and cpu_wr_req is 1 at a clock edge, the next cycle shows mem_stb=1, mem_cyc=1, mem_we=1 and cpu_ready=0.
- R4: mem_stb and mem_cyc are equal on every cycle.
- R5: While mem_stb is 1 and mem_ack is 0, the next cycle keeps mem_stb, mem_we, mem_bank, mem_word and mem_wdata unchanged.
- R6: An edge with mem_stb=1 and mem_ack=1 drops mem_stb, mem_cyc and mem_we to 0 and raises cpu_ready to 1 in the following cycle. mem_ack is ignored while mem_stb is 0.
- R7: The byte address is {block[6:0], cpu_addr[15:0]}. mem_bank is bits [22:21], mem_word is bits [20:1], and bit 0 (cpu_addr[0]) is the byte select. All of these are taken from the values present at the accepting edge.
- R8: On a write, mem_wdata carries cpu_wdata in bits [7:0] for byte select 0 or in bits [15:8] for byte select 1. All other bits are 0. On a read, mem_wdata is 0.
- R9: On a read acknowledge, cpu_rdata takes mem_rdata[7:0] for byte select 0 or mem_rdata[15:8] for byte select 1. Bits [31:16] and the other byte are ignored. cpu_rdata keeps that value until the next read completes.
- R10: cpu_rd_req and cpu_wr_req are ignored while cpu_ready is 0. No new handshake starts and the held address and data do not change.
- R11: A clock edge with blk_wr=1 loads blk_wdata into the block-select register. A request accepted on that same edge still uses the previous register value.
- R12: If cpu_rd_req and cpu_wr_req are both 1 when a request is accepted, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_req | input | 1 | CPU read request |
| cpu_wr_req | input | 1 | CPU write request |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned by the last read |
| cpu_ready | output | 1 | High when a new request can be accepted |
| blk_wr | input | 1 | Block-select register load strobe |
| blk_wdata | input | 7 | Block-select value |
| mem_we | output | 1 | Write flag to the controller (1 write, 0 read) |
| mem_stb | output | 1 | Command strobe |
| mem_cyc | output | 1 | Cycle qualifier, same timing as the strobe |
| mem_bank | output | 2 | Bank select |
| mem_word | output | 20 | 16-bit word index within the bank |
| mem_wdata | output | 32 | Write data with the byte on its lane |
| mem_rdata | input | 32 | Read data from the controller |
| mem_ack | input | 1 | Controller acknowledge |

## Verification
Assertions check these rules on every cycle:
- the strobe and cycle-qualifier move together;
- the address, write flag and data stay frozen while an acknowledge is awaited;
- the port is released and ready returns one cycle after the acknowledge;
- ready stays low while a strobe is out;
- both accept transitions behave as required;
- the write data's upper half stays zero;
- block-select loads take effect.

Other behaviours need the bench's cycle-accurate model, because they depend on data values across several transactions. These are the exact bank and word split of the extended address, the choice of lane for each byte select, read data holding between reads, the priority of a write over a read, requests ignored while busy, stray acknowledges, and a block-select load on the same edge as an accept.

// File: rtl/cpu_dram_bridge_pkg.sv
package cpu_dram_bridge_pkg;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_RD   = 2'd1,
        BR_WR   = 2'd2
    } bridge_state_e;

endpackage

// File: rtl/bridge_blk_reg.sv
module bridge_blk_reg #(
    parameter int BLK_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] load_val,
    output logic [BLK_W-1:0] blk
);

    logic [BLK_W-1:0] blk_d, blk_q;

    always_comb begin
        blk_d = blk_q;
        if (load) blk_d = load_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    assign blk = blk_q;

    a_r11_block_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (blk == $past(load_val)));

endmodule

// File: rtl/bridge_addr_map.sv
module bridge_addr_map #(
    parameter int CPU_AW = 16,
    parameter int BLK_W  = 7,
    parameter int BANK_W = 2,
    parameter int SEL_W  = 1,
    localparam int BYTE_AW = CPU_AW + BLK_W,
    localparam int WORD_W  = BYTE_AW - BANK_W - SEL_W
) (
    input  logic [BLK_W-1:0]  blk,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [BANK_W-1:0] bank,
    output logic [WORD_W-1:0] word,
    output logic [SEL_W-1:0]  sel
);

    logic [BYTE_AW-1:0] byte_addr;

    always_comb begin
        byte_addr = {blk, cpu_addr};
        bank      = byte_addr[BYTE_AW-1 -: BANK_W];
        word      = byte_addr[BYTE_AW-BANK_W-1 : SEL_W];
        sel       = byte_addr[SEL_W-1:0];
    end

endmodule

// File: rtl/bridge_lane.sv
module bridge_lane #(
    parameter int CPU_DW  = 8,
    parameter int WORD_DW = 16,
    parameter int MEM_DW  = 32,
    localparam int LANES  = WORD_DW / CPU_DW,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CPU_DW-1:0] wr_byte,
    output logic [MEM_DW-1:0] wr_word,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [MEM_DW-1:0] rd_word,
    output logic [CPU_DW-1:0] rd_byte
);

    logic [LANES-1:0][CPU_DW-1:0] lane_wr;
    logic [LANES-1:0][CPU_DW-1:0] lane_rd;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [SEL_W-1:0] LANE_ID = SEL_W'(g);
        assign lane_wr[g] = (wr_sel == LANE_ID) ? wr_byte : '0;
        assign lane_rd[g] = (rd_sel == LANE_ID) ? rd_word[g*CPU_DW +: CPU_DW] : '0;
    end

    if (MEM_DW > WORD_DW) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^rd_word[MEM_DW-1:WORD_DW];
        assign wr_word = {{(MEM_DW-WORD_DW){1'b0}}, lane_wr};
    end else begin : g_exact
        assign wr_word = lane_wr;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++) rd_byte = rd_byte | lane_rd[i];
    end

endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import cpu_dram_bridge_pkg::*;
#(
    parameter int CPU_DW = 8,
    parameter int MEM_DW = 32,
    parameter int BANK_W = 2,
    parameter int WORD_W = 20,
    parameter int SEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [MEM_DW-1:0] wdata_in,
    input  logic [CPU_DW-1:0] rbyte_in,
    input  logic              ack,
    output logic              stb,
    output logic              cyc,
    output logic              we,
    output logic              ready,
    output logic [BANK_W-1:0] bank,
    output logic [WORD_W-1:0] word,
    output logic [SEL_W-1:0]  sel,
    output logic [MEM_DW-1:0] wdata,
    output logic [CPU_DW-1:0] rdata
);

    typedef struct packed {
        bridge_state_e     state;
        logic              stb;
        logic              cyc;
        logic              we;
        logic              ready;
        logic [BANK_W-1:0] bank;
        logic [WORD_W-1:0] word;
        logic [SEL_W-1:0]  sel;
        logic [MEM_DW-1:0] wdata;
        logic [CPU_DW-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            BR_IDLE: begin
                if (wr_req || rd_req) begin
                    seq_d.state = wr_req ? BR_WR : BR_RD;
                    seq_d.we    = wr_req;
                    seq_d.stb   = 1'b1;
                    seq_d.cyc   = 1'b1;
                    seq_d.ready = 1'b0;
                    seq_d.bank  = bank_in;
                    seq_d.word  = word_in;
                    seq_d.sel   = sel_in;
                    seq_d.wdata = wr_req ? wdata_in : '0;
                end
            end
            BR_RD: begin
                if (ack) begin
                    seq_d.rdata = rbyte_in;
                    seq_d.stb   = 1'b0;
                    seq_d.cyc   = 1'b0;
                    seq_d.ready = 1'b1;
                    seq_d.state = BR_IDLE;
                end
            end
            BR_WR: begin
                if (ack) begin
                    seq_d.we    = 1'b0;
                    seq_d.stb   = 1'b0;
                    seq_d.cyc   = 1'b0;
                    seq_d.ready = 1'b1;
                    seq_d.state = BR_IDLE;
                end
            end
            default: begin
                seq_d.state = BR_IDLE;
                seq_d.stb   = 1'b0;
                seq_d.cyc   = 1'b0;
                seq_d.we    = 1'b0;
                seq_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= BR_IDLE;
            seq_q.ready <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stb   = seq_q.stb;
    assign cyc   = seq_q.cyc;
    assign we    = seq_q.we;
    assign ready = seq_q.ready;
    assign bank  = seq_q.bank;
    assign word  = seq_q.word;
    assign sel   = seq_q.sel;
    assign wdata = seq_q.wdata;
    assign rdata = seq_q.rdata;

    a_r4_stb_cyc_together: assert property (@(posedge clk) disable iff (!rst_n)
        stb == cyc);

    a_r5_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ack) |=> (stb && $stable(we) && $stable(bank) && $stable(word) && $stable(wdata)));

    a_r6_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ack) |=> (!stb && !cyc && !we && ready));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> !ready);

    a_r2_read_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_req && !wr_req) |=> (stb && cyc && !we && !ready));

    a_r3_write_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_req) |=> (stb && cyc && we && !ready));

endmodule

// File: rtl/cpu_dram_bridge.sv
module cpu_dram_bridge #(
    parameter int CPU_AW  = 16,
    parameter int CPU_DW  = 8,
    parameter int BLK_W   = 7,
    parameter int BANK_W  = 2,
    parameter int WORD_DW = 16,
    parameter int MEM_DW  = 32,
    localparam int LANES  = WORD_DW / CPU_DW,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = CPU_AW + BLK_W - BANK_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_req,
    input  logic              cpu_wr_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    output logic [CPU_DW-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              blk_wr,
    input  logic [BLK_W-1:0]  blk_wdata,
    output logic              mem_we,
    output logic              mem_stb,
    output logic              mem_cyc,
    output logic [BANK_W-1:0] mem_bank,
    output logic [WORD_W-1:0] mem_word,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [BLK_W-1:0]  blk;
    logic [BANK_W-1:0] map_bank;
    logic [WORD_W-1:0] map_word;
    logic [SEL_W-1:0]  map_sel;
    logic [SEL_W-1:0]  held_sel;
    logic [MEM_DW-1:0] ins_word;
    logic [CPU_DW-1:0] ext_byte;

    bridge_blk_reg #(.BLK_W(BLK_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (blk_wr),
        .load_val (blk_wdata),
        .blk      (blk)
    );

    bridge_addr_map #(
        .CPU_AW (CPU_AW),
        .BLK_W  (BLK_W),
        .BANK_W (BANK_W),
        .SEL_W  (SEL_W)
    ) u_map (
        .blk      (blk),
        .cpu_addr (cpu_addr),
        .bank     (map_bank),
        .word     (map_word),
        .sel      (map_sel)
    );

    bridge_lane #(
        .CPU_DW  (CPU_DW),
        .WORD_DW (WORD_DW),
        .MEM_DW  (MEM_DW)
    ) u_lane (
        .wr_sel  (map_sel),
        .wr_byte (cpu_wdata),
        .wr_word (ins_word),
        .rd_sel  (held_sel),
        .rd_word (mem_rdata),
        .rd_byte (ext_byte)
    );

    bridge_seq #(
        .CPU_DW (CPU_DW),
        .MEM_DW (MEM_DW),
        .BANK_W (BANK_W),
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (cpu_rd_req),
        .wr_req   (cpu_wr_req),
        .bank_in  (map_bank),
        .word_in  (map_word),
        .sel_in   (map_sel),
        .wdata_in (ins_word),
        .rbyte_in (ext_byte),
        .ack      (mem_ack),
        .stb      (mem_stb),
        .cyc      (mem_cyc),
        .we       (mem_we),
        .ready    (cpu_ready),
        .bank     (mem_bank),
        .word     (mem_word),
        .sel      (held_sel),
        .wdata    (mem_wdata),
        .rdata    (cpu_rdata)
    );

    if (MEM_DW > WORD_DW) begin : g_chk_upper
        a_r8_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
            mem_stb |-> (mem_wdata[MEM_DW-1:WORD_DW] == '0));
    end

    a_r8_read_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_we) |-> (mem_wdata == '0));

endmodule

// File: tb/cpu_dram_bridge_bench.sv
module cpu_dram_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd_req = 1'b0;
    logic        cpu_wr_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        blk_wr = 1'b0;
    logic [6:0]  blk_wdata = '0;
    logic        mem_we, mem_stb, mem_cyc;
    logic [1:0]  mem_bank;
    logic [19:0] mem_word;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    bit          m_busy, m_we, m_ready, m_sel;
    int unsigned m_bank, m_word, m_wdata, m_rdata, m_blk;

    always #2.5 clk = ~clk;

    cpu_dram_bridge u_cpu_dram_bridge (
        .clk(clk), .rst_n(rst_n),
        .cpu_rd_req(cpu_rd_req), .cpu_wr_req(cpu_wr_req),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .blk_wr(blk_wr), .blk_wdata(blk_wdata),
        .mem_we(mem_we), .mem_stb(mem_stb), .mem_cyc(mem_cyc),
        .mem_bank(mem_bank), .mem_word(mem_word), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2/R3/R6 mem_stb", mem_stb, m_busy);
        chk("R4 mem_cyc", mem_cyc, m_busy);
        chk("R2/R3/R12 mem_we", mem_we, m_we);
        chk("R6/R10 cpu_ready", cpu_ready, m_ready);
        chk("R7 mem_bank", mem_bank, m_bank);
        chk("R7/R11 mem_word", mem_word, m_word);
        chk("R8/R5 mem_wdata", mem_wdata, m_wdata);
        chk("R9 cpu_rdata", cpu_rdata, m_rdata);
    endtask

    task automatic model_reset();
        m_busy = 0; m_we = 0; m_ready = 1; m_sel = 0;
        m_bank = 0; m_word = 0; m_wdata = 0; m_rdata = 0; m_blk = 0;
    endtask

    // one clock: model next state from present inputs, edge, compare mid-cycle
    task automatic step();
        bit          n_busy = m_busy, n_we = m_we, n_ready = m_ready, n_sel = m_sel;
        int unsigned n_bank = m_bank, n_word = m_word, n_wdata = m_wdata;
        int unsigned n_rdata = m_rdata, n_blk = m_blk;
        int unsigned full;
        if (!m_busy) begin
            if (cpu_rd_req || cpu_wr_req) begin
                full    = (m_blk << 16) | cpu_addr;
                n_busy  = 1;
                n_ready = 0;
                n_we    = cpu_wr_req;
                n_bank  = (full >> 21) & 3;
                n_word  = (full >> 1) & 32'hF_FFFF;
                n_sel   = full[0];
                n_wdata = cpu_wr_req ? (n_sel ? (cpu_wdata << 8) : cpu_wdata) : 0;
            end
        end else if (mem_ack) begin
            n_busy  = 0;
            n_ready = 1;
            if (!m_we) n_rdata = m_sel ? ((mem_rdata >> 8) & 8'hFF) : (mem_rdata & 8'hFF);
            n_we    = 0;
        end
        if (blk_wr) n_blk = blk_wdata;
        @(posedge clk);
        m_busy = n_busy; m_we = n_we; m_ready = n_ready; m_sel = n_sel;
        m_bank = n_bank; m_word = n_word; m_wdata = n_wdata; m_rdata = n_rdata; m_blk = n_blk;
        @(negedge clk);
        compare_all();
    endtask

    // one CPU access; busy_noise drives ignored requests while waiting (R10)
    task automatic access(bit wr, bit rd, logic [15:0] a, logic [7:0] d,
                          int lat, logic [31:0] rword, bit busy_noise);
        cpu_wr_req = wr; cpu_rd_req = rd; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_wr_req = 0; cpu_rd_req = 0;
        for (int i = 0; i < lat; i++) begin
            if (busy_noise) begin
                cpu_rd_req = 1; cpu_wr_req = i[0];
                cpu_addr = 16'hA5A5 ^ 16'(i); cpu_wdata = 8'h3C;
            end
            step();
        end
        cpu_rd_req = 0; cpu_wr_req = 0;
        mem_ack = 1; mem_rdata = rword;
        step();
        mem_ack = 0; mem_rdata = 32'hFFFF_FFFF;
        step();
    endtask

    initial begin
        int cyc_cnt = 0;
        while (!done) begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 20000) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=hung expected=finished");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        compare_all();
        step();
        // R2 R9: read, odd byte, upper bits and other byte ignored
        access(0, 1, 16'h1235, 8'h00, 3, 32'hDEAD_BEEF, 0);
        // R3 R8: write low lane, zero-latency ack
        access(1, 0, 16'h0010, 8'h5A, 0, 32'h0, 0);
        // R8: write high lane
        access(1, 0, 16'h8001, 8'hC3, 2, 32'h0, 0);
        // R6: stray ack while idle is ignored
        mem_ack = 1; mem_rdata = 32'h1234_5678; step(); mem_ack = 0; step();
        // R11 R7: load block select, then top of memory
        blk_wr = 1; blk_wdata = 7'h7F; step(); blk_wr = 0;
        access(0, 1, 16'hFFFF, 8'h00, 1, 32'h0000_A1B2, 0);
        // R9: low-byte read
        access(0, 1, 16'h4000, 8'h00, 2, 32'h7777_9988, 0);
        // R10: requests while busy are ignored
        access(0, 1, 16'h2222, 8'h00, 5, 32'h0000_1155, 1);
        // R12: read and write together -> write wins
        access(1, 1, 16'h0101, 8'h96, 1, 32'hFFFF_FFFF, 0);
        // R11: block load on the same edge as an accept uses old value
        blk_wr = 1; blk_wdata = 7'h21;
        cpu_rd_req = 1; cpu_addr = 16'h0FF0;
        step();
        blk_wr = 0; cpu_rd_req = 0;
        mem_ack = 1; mem_rdata = 32'h0000_00EE; step(); mem_ack = 0; step();
        access(0, 1, 16'h0FF1, 8'h00, 0, 32'h0000_4400, 0);
        // R5: long wait holds everything steady
        blk_wr = 1; blk_wdata = 7'h35; step(); blk_wr = 0;
        access(1, 0, 16'hBEEF, 8'h81, 8, 32'h0, 1);
        // R1: reset mid-transaction returns to reset state
        cpu_rd_req = 1; cpu_addr = 16'h0003; step(); cpu_rd_req = 0;
        rst_n = 0; @(posedge clk); model_reset(); @(negedge clk); rst_n = 1;
        compare_all();
        access(0, 1, 16'h0003, 8'h00, 1, 32'h0000_6600, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule